// File: doc/BRIEF.md
# Coprocessor Escape Handshake Unit

This unit sits next to a host processor and follows the instruction stream the host consumes from its prefetch queue. When the host starts an instruction whose first byte carries the escape tag, the unit takes the instruction for the coprocessor and combines the low bits of that byte with the following byte into a coprocessor opcode. When the second byte selects a memory operand, the unit waits for the host's dummy read and latches the address the host placed on the bus. Every other instruction is left to the host.

Once an escape instruction has been taken, the unit raises a busy line that feeds the host's test input. The line stays high for a latency that depends on the opcode, which stands in for the real arithmetic. The host keeps executing its own instructions in parallel. When the host executes a wait instruction, a gate stalls it for as long as busy is high. If the host consumes a new escape instruction while busy is still high, a sticky protocol error is raised and that instruction is discarded.

Top module: `cop_escape_interlock`

## Requirements
- R1: After reset, busy, host_stall and proto_err are low, and op_code and op_addr are zero.
- R2: An escape starts only on a cycle with fetch_valid high, fetch_qs = 2'b01 (first byte of an instruction) and fetch_byte[7:3] = 5'b11011. A first byte without the tag, a byte with fetch_qs = 2'b00, and a byte with fetch_qs = 2'b11 that does not follow a tagged first byte are all ignored: busy, op_code and op_addr do not change.
- R3: After a launch, op_code holds {first byte[2:0], second byte}, which is 11 bits wide.
- R4: The second byte is the one delivered with fetch_qs = 2'b11. If its bits [7:6] are 2'b11, the launch happens on that cycle. Otherwise the launch happens on the first later cycle with bus_rd high, and op_addr takes bus_addr from that cycle.
- R5: busy rises in the cycle after a launch. It stays high for exactly LAT_BASE + LAT_STEP * first byte[2:0] cycles (3 + 2*n with the default parameters) and then falls.
- R6: host_stall is high exactly in the cycles where host_wait and busy are both high.
- R7: Non-escape fetches and bus reads that occur while busy is high neither shorten nor extend busy.
- R8: fetch_qs = 2'b10 (queue flush) abandons an escape that is only partly decoded, so no launch follows from it.
- R9: When a tagged first byte is consumed while busy is high, proto_err goes high in the next cycle and stays high until reset. That escape is discarded: busy is not extended, and op_code and op_addr keep their values.
- R10: op_addr changes only on the dummy read of a memory-operand escape. Other bus reads leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | fetch_byte is meaningful this cycle |
| fetch_qs | input | 2 | Queue status hint: 00 none, 01 first byte, 10 flush, 11 subsequent byte |
| fetch_byte | input | 8 | Instruction byte consumed by the host |
| bus_rd | input | 1 | Host bus read strobe |
| bus_addr | input | ADDR_W | Host bus address |
| host_wait | input | 1 | Host is executing a wait instruction |
| busy | output | 1 | Coprocessor busy, driven to the host test input |
| host_stall | output | 1 | Stall request to the host |
| proto_err | output | 1 | Sticky flag: an escape overlapped a busy period |
| op_code | output | 11 | Opcode of the last launched escape |
| op_addr | output | ADDR_W | Operand address of the last memory-form escape |

## Verification
On every cycle the assertions check several relations. A rise of busy must follow either a second byte or a bus read. A busy run must never exceed the longest possible latency. The stall must be low once busy has fallen. The error flag must stay set once raised, and it may only be raised while busy. The operand address must stay steady unless a read was seen. Only the bench's scenarios can show the rest: the exact busy length for each opcode, the opcode and address values, whether non-escape traffic, queue flushes and untagged bytes are really ignored, and that an overlapping escape is dropped without disturbing the running one.

// File: rtl/cop_esc_pkg.sv
package cop_esc_pkg;
    typedef enum logic [1:0] {
        QS_NONE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qs_e;

    typedef enum logic [1:0] {
        DEC_IDLE,
        DEC_MODRM,
        DEC_DUMMY
    } dec_state_e;

    localparam int unsigned OPC_W = 11;
    localparam logic [1:0] MOD_REG_ONLY = 2'b11;
endpackage

// File: rtl/cop_esc_decode.sv
module cop_esc_decode
    import cop_esc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 20,
    parameter logic [4:0]  ESC_TAG = 5'b11011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [1:0]        fetch_qs,
    input  logic [7:0]        fetch_byte,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              busy,
    output logic              launch,
    output logic [2:0]        launch_sel,
    output logic              esc_first,
    output logic [OPC_W-1:0]  op_code,
    output logic [ADDR_W-1:0] op_addr
);
    typedef struct packed {
        dec_state_e        st;
        logic [2:0]        sel;
        logic [7:0]        modrm;
        logic              overlap;
        logic [OPC_W-1:0]  code;
        logic [ADDR_W-1:0] addr;
    } dec_t;

    dec_t dec_d, dec_q;
    qs_e  qs;
    logic is_first, is_next, is_tag;

    always_comb begin
        qs        = qs_e'(fetch_qs);
        is_first  = fetch_valid && (qs == QS_FIRST);
        is_next   = fetch_valid && (qs == QS_NEXT);
        is_tag    = (fetch_byte[7:3] == ESC_TAG);
        dec_d     = dec_q;
        launch    = 1'b0;
        esc_first = 1'b0;
        if (qs == QS_FLUSH) begin
            dec_d.st = DEC_IDLE;
        end else if (is_first) begin
            if (is_tag) begin
                dec_d.st      = DEC_MODRM;
                dec_d.sel     = fetch_byte[2:0];
                dec_d.overlap = busy;
                esc_first     = 1'b1;
            end else begin
                dec_d.st = DEC_IDLE;
            end
        end else begin
            case (dec_q.st)
                DEC_MODRM: begin
                    if (is_next) begin
                        dec_d.modrm = fetch_byte;
                        if (fetch_byte[7:6] == MOD_REG_ONLY) begin
                            dec_d.st = DEC_IDLE;
                            if (!dec_q.overlap) begin
                                launch     = 1'b1;
                                dec_d.code = {dec_q.sel, fetch_byte};
                            end
                        end else begin
                            dec_d.st = DEC_DUMMY;
                        end
                    end
                end
                DEC_DUMMY: begin
                    if (bus_rd) begin
                        dec_d.st = DEC_IDLE;
                        if (!dec_q.overlap) begin
                            launch     = 1'b1;
                            dec_d.code = {dec_q.sel, dec_q.modrm};
                            dec_d.addr = bus_addr;
                        end
                    end
                end
                default: dec_d.st = DEC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '{st: DEC_IDLE, sel: '0, modrm: '0, overlap: 1'b0,
                       code: '0, addr: '0};
        end else begin
            dec_q <= dec_d;
        end
    end

    assign launch_sel = dec_q.sel;
    assign op_code    = dec_q.code;
    assign op_addr    = dec_q.addr;
endmodule

// File: rtl/cop_exec_timer.sv
module cop_exec_timer #(
    parameter int unsigned LAT_BASE = 3,
    parameter int unsigned LAT_STEP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  logic [2:0] sel,
    output logic       busy
);
    localparam int unsigned MAX_LAT = LAT_BASE + 7 * LAT_STEP;
    localparam int unsigned CNT_W   = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == CNT_W'(1)) begin
                tmr_d.busy = 1'b0;
                tmr_d.cnt  = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
            end
        end else if (launch) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CNT_W'(LAT_BASE) + CNT_W'(LAT_STEP) * CNT_W'(sel);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy = tmr_q.busy;
endmodule

// File: rtl/cop_wait_gate.sv
module cop_wait_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic host_wait,
    input  logic busy,
    input  logic esc_first,
    output logic host_stall,
    output logic proto_err
);
    logic err_d, err_q;

    always_comb begin
        err_d      = err_q | (esc_first & busy);
        host_stall = host_wait & busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_d;
        end
    end

    assign proto_err = err_q;
endmodule

// File: rtl/cop_escape_interlock.sv
module cop_escape_interlock
    import cop_esc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 20,
    parameter logic [4:0]  ESC_TAG  = 5'b11011,
    parameter int unsigned LAT_BASE = 3,
    parameter int unsigned LAT_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [1:0]        fetch_qs,
    input  logic [7:0]        fetch_byte,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              host_wait,
    output logic              busy,
    output logic              host_stall,
    output logic              proto_err,
    output logic [OPC_W-1:0]  op_code,
    output logic [ADDR_W-1:0] op_addr
);
    logic       launch;
    logic [2:0] launch_sel;
    logic       esc_first;

    cop_esc_decode #(
        .ADDR_W (ADDR_W),
        .ESC_TAG(ESC_TAG)
    ) i_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_valid(fetch_valid),
        .fetch_qs   (fetch_qs),
        .fetch_byte (fetch_byte),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .busy       (busy),
        .launch     (launch),
        .launch_sel (launch_sel),
        .esc_first  (esc_first),
        .op_code    (op_code),
        .op_addr    (op_addr)
    );

    cop_exec_timer #(
        .LAT_BASE(LAT_BASE),
        .LAT_STEP(LAT_STEP)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .launch(launch),
        .sel   (launch_sel),
        .busy  (busy)
    );

    cop_wait_gate i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wait (host_wait),
        .busy      (busy),
        .esc_first (esc_first),
        .host_stall(host_stall),
        .proto_err (proto_err)
    );
endmodule

// File: rtl/cop_esc_checker.sv
module cop_esc_checker #(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned LAT_BASE = 3,
    parameter int unsigned LAT_STEP = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic [1:0]        fetch_qs,
    input logic              bus_rd,
    input logic              busy,
    input logic              host_stall,
    input logic              proto_err,
    input logic [ADDR_W-1:0] op_addr
);
    localparam int unsigned MAX_LAT = LAT_BASE + 7 * LAT_STEP;
    localparam int unsigned RUN_W   = $clog2(MAX_LAT + 2) + 1;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            if (run_q != '1) run_q <= run_q + RUN_W'(1);
        end else begin
            run_q <= '0;
        end
    end

    // R4: busy only starts after a second byte or a dummy read
    assert_busy_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(fetch_valid && fetch_qs == 2'b11) || $past(bus_rd)));

    // R5: no busy run longer than the longest latency
    assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(MAX_LAT));

    // R6: stall released once busy has fallen
    assert_stall_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !host_stall);

    // R9: error flag is sticky
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R9: error can only appear while busy was high
    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err) |-> $past(busy));

    // R10: operand address changes only after a read
    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(op_addr));
endmodule

bind cop_escape_interlock cop_esc_checker #(
    .ADDR_W  (ADDR_W),
    .LAT_BASE(LAT_BASE),
    .LAT_STEP(LAT_STEP)
) i_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_valid(fetch_valid),
    .fetch_qs   (fetch_qs),
    .bus_rd     (bus_rd),
    .busy       (busy),
    .host_stall (host_stall),
    .proto_err  (proto_err),
    .op_addr    (op_addr)
);

// File: tb/test_cop_escape_interlock.sv
module test_cop_escape_interlock;
    localparam int ADDR_W = 20;
    localparam logic [4:0] TAG = 5'b11011;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fetch_valid = 1'b0;
    logic [1:0]        fetch_qs = 2'b00;
    logic [7:0]        fetch_byte = 8'h00;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              host_wait = 1'b0;
    logic              busy, host_stall, proto_err;
    logic [10:0]       op_code;
    logic [ADDR_W-1:0] op_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [10:0]       exp_code = '0;
    logic [ADDR_W-1:0] exp_addr = '0;

    cop_escape_interlock i_cop_escape_interlock (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_qs(fetch_qs),
        .fetch_byte(fetch_byte), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .host_wait(host_wait), .busy(busy), .host_stall(host_stall),
        .proto_err(proto_err), .op_code(op_code), .op_addr(op_addr)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected under 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int lat(input logic [2:0] sel);
        return 3 + 2 * int'(sel);
    endfunction

    function automatic logic [7:0] plain_byte();
        logic [7:0] b;
        do b = 8'($urandom); while (b[7:3] == TAG);
        return b;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        fetch_valid = 1'b0; fetch_qs = 2'b00; fetch_byte = 8'h00;
        bus_rd = 1'b0; host_wait = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); idle_inputs(); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_code = '0; exp_addr = '0;
    endtask

    task automatic check_quiet(input string req);
        chk(busy == 1'b0, req, "busy", busy, 0);
        chk(op_code == exp_code, req, "op_code", op_code, exp_code);
        chk(op_addr == exp_addr, req, "op_addr", op_addr, exp_addr);
    endtask

    // Drives one escape then follows the busy window.
    task automatic run_escape(input logic [2:0] sel, input logic [7:0] modrm,
                              input logic [ADDR_W-1:0] addr, input int gap,
                              input bit noise, input bit intrude);
        int L;
        bit w;
        L = lat(sel);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_qs = 2'b01; fetch_byte = {TAG, sel};
        @(negedge clk);
        fetch_qs = 2'b11; fetch_byte = modrm;
        if (modrm[7:6] != 2'b11) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk); idle_inputs();
            end
            @(negedge clk); idle_inputs();
            bus_rd = 1'b1; bus_addr = addr;
            exp_addr = addr;
        end
        exp_code = {sel, modrm};
        @(negedge clk);
        for (int k = 0; k < L + 2; k++) begin
            idle_inputs();
            w = 1'($urandom);
            host_wait = w;
            if (intrude && k == 1) begin
                fetch_valid = 1'b1; fetch_qs = 2'b01; fetch_byte = {TAG, 3'($urandom)};
            end else if (intrude && k == 2) begin
                fetch_valid = 1'b1; fetch_qs = 2'b11; fetch_byte = 8'hC0 | 8'($urandom % 64);
            end else if (noise && ($urandom % 3 == 0)) begin
                fetch_valid = 1'b1; fetch_qs = 2'b01; fetch_byte = plain_byte();
                bus_rd = 1'($urandom); bus_addr = ADDR_W'($urandom);
            end
            #1;
            chk(busy == (k < L), "R5", "busy window", busy, (k < L));
            chk(host_stall == (w && (k < L)), "R6", "stall", host_stall, (w && (k < L)));
            if (k == 0) begin
                chk(op_code == exp_code, "R3", "op_code", op_code, exp_code);
                chk(op_addr == exp_addr, "R4", "op_addr", op_addr, exp_addr);
            end
            if (intrude && k >= 2) begin
                chk(proto_err == 1'b1, "R9", "proto_err", proto_err, 1);
                chk(op_code == exp_code, "R9", "op_code kept", op_code, exp_code);
                chk(op_addr == exp_addr, "R9", "op_addr kept", op_addr, exp_addr);
            end
            @(negedge clk);
        end
        idle_inputs();
    endtask

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        #1;
        // R1: reset state
        chk(busy == 0, "R1", "busy", busy, 0);
        chk(host_stall == 0, "R1", "stall", host_stall, 0);
        chk(proto_err == 0, "R1", "proto_err", proto_err, 0);
        chk(op_code == 0, "R1", "op_code", op_code, 0);
        chk(op_addr == 0, "R1", "op_addr", op_addr, 0);

        // R2, R10: untagged, unqualified and stray subsequent bytes plus reads are ignored
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            idle_inputs();
            case (i % 3)
                0: begin fetch_valid = 1; fetch_qs = 2'b01; fetch_byte = plain_byte(); end
                1: begin fetch_valid = 1; fetch_qs = 2'b11; fetch_byte = {TAG, 3'($urandom)}; end
                default: begin fetch_valid = 1; fetch_qs = 2'b00; fetch_byte = {TAG, 3'($urandom)}; end
            endcase
            bus_rd = 1'($urandom); bus_addr = ADDR_W'($urandom);
            host_wait = 1'($urandom);
            #1;
            chk(host_stall == 0, "R6", "stall idle", host_stall, 0);
        end
        @(negedge clk); idle_inputs(); #1;
        check_quiet("R2");
        check_quiet("R10");

        // R3, R4, R5: register form, shortest latency
        run_escape(3'd0, 8'hC5, '0, 0, 0, 0);
        // R4: memory form, longest latency, immediate dummy read
        run_escape(3'd7, 8'h06, 20'hABCDE, 0, 0, 0);
        // R4: memory form with gap before dummy read, R7 noise during busy
        run_escape(3'd2, 8'h47, 20'h12345, 3, 1, 0);

        // R8: flush abandons partial escape
        @(negedge clk);
        fetch_valid = 1; fetch_qs = 2'b01; fetch_byte = {TAG, 3'd4};
        @(negedge clk);
        fetch_valid = 0; fetch_qs = 2'b10;
        @(negedge clk);
        fetch_valid = 1; fetch_qs = 2'b11; fetch_byte = 8'hD1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); idle_inputs(); bus_rd = 1; bus_addr = 20'h55555; #1;
            chk(busy == 0, "R8", "busy after flush", busy, 0);
        end
        @(negedge clk); idle_inputs(); #1;
        check_quiet("R8");

        // R9: overlapping escape sets sticky error and is dropped
        run_escape(3'd3, 8'hD8, '0, 0, 0, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(proto_err == 1, "R9", "sticky", proto_err, 1);
        end
        do_reset();
        #1;
        chk(proto_err == 0, "R9", "cleared by reset", proto_err, 0);

        // Random mix: R3 R4 R5 R6 R7
        for (int n = 0; n < 40; n++) begin
            logic [7:0] m;
            m = 8'($urandom);
            run_escape(3'($urandom), m, ADDR_W'($urandom), int'($urandom % 4), 1, 0);
            for (int i = 0; i < int'($urandom % 3); i++) begin
                @(negedge clk); fetch_valid = 1; fetch_qs = 2'b01; fetch_byte = plain_byte();
            end
            @(negedge clk); idle_inputs(); #1;
            check_quiet("R7");
        end
        chk(proto_err == 0, "R9", "no error in clean run", proto_err, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule